// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This block takes one byte-granular cache maintenance request and breaks it into the commands a cache controller can execute. A request names a start address, an end address that is exclusive, and an operation: invalidate, clean, or flush (clean followed by invalidate). The block emits two kinds of command. One acts on a single line (clean-and-invalidate). The other acts on an inclusive range of whole lines (range clean or range invalidate). Commands leave over a valid/ready handshake in ascending address order.

For invalidate, a partial line at either end of the span cannot simply be dropped, because it also holds bytes outside the request. The block therefore writes such a line back and invalidates it with a single-line command, and it invalidates only the whole lines in between. For clean and flush, the span is widened to whole lines. Whole-line spans are cut into chunks. A chunk never exceeds a maximum length and never crosses a page, so no single command stalls the controller for long. When the cache runs in write-through override mode it never holds dirty data, so cleaning is skipped. Once the final command has been taken, the block raises done for one cycle and then a barrier pulse for one cycle, and it becomes idle again.

Top module: `cache_range_splitter`

## Requirements
- R1: `reqReady` is high only while the block is idle and not signalling a command, done or barrier. A request is taken on a cycle where `reqValid` and `reqReady` are both high. `wtOverride` is sampled at that moment and held for the whole request. `reqValid` has no effect while the block is busy.
- R2: `cmdKind` encodes the command: 0 is single-line clean-and-invalidate, with `cmdLast` equal to `cmdAddr`. 1 is range clean and 2 is range invalidate. Every command address is line aligned (32-byte lines), and `cmdLast` is the address of the first byte of the last line covered.
- R3: A range command covers at most 1024 bytes, and `cmdAddr` and `cmdLast` lie in the same 4096-byte page. Each chunk ends at the earliest of: the span end, start plus 1024, or the next page boundary.
- R4: Invalidate (op 0) with an unaligned start issues a line command on the line holding start. Range work then begins at the next line boundary.
- R5: Invalidate with an unaligned end issues a line command on the line holding end, provided the rounded-up start is still below end. Range work then stops at that line. No tail command is issued when the whole request sits in the head line.
- R6: Clean (op 1) and flush (op 2, and also op 3) round start down and end up to line boundaries before chunking.
- R7: Flush issues, for each chunk, a range clean followed by a range invalidate with identical addresses. Invalidate issues only range invalidates.
- R8: With write-through override, clean issues no commands and flush issues only the range invalidate of each chunk.
- R9: Order is: head line command, then tail line command, then chunks in ascending address order.
- R10: While `cmdValid` is high and `cmdReady` is low, `cmdValid`, `cmdKind`, `cmdAddr` and `cmdLast` hold their values.
- R11: `done` is high for exactly one cycle, the cycle after the final command handshake. `barrier` is high for the following cycle only, and `reqReady` returns the cycle after that.
- R12: A request that yields no commands (empty after alignment, or clean under override) raises `done` in the cycle after it is taken, and still produces the barrier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request can be taken |
| reqStart | input | AW | First byte of the request |
| reqEnd | input | AW | Byte after the last byte of the request |
| reqOp | input | 2 | 0 invalidate, 1 clean, 2 or 3 flush |
| wtOverride | input | 1 | Cache is in write-through override mode |
| cmdValid | output | 1 | Command offered |
| cmdReady | input | 1 | Command taken by the controller |
| cmdKind | output | 2 | 0 line clean-and-invalidate, 1 range clean, 2 range invalidate |
| cmdAddr | output | AW | First line address of the command |
| cmdLast | output | AW | Inclusive last line address of the command |
| done | output | 1 | One-cycle pulse after the final command |
| barrier | output | 1 | One-cycle pulse after done |

## Verification
The bench goes after spans that start just below a page boundary. A design that clamped only to the 1024-byte cap would emit a range reaching into the next page. It also uses invalidate requests lying inside a single line. A design that skipped the start-below-end test would issue a second, duplicate line command on the head line, or a chunk that runs backwards. Flush under override and clean under override are compared against each other. A design that tested the wrong opcode would clean under override or drop the invalidate. Stalled handshakes and a mode change after acceptance show whether the payload holds steady and whether the override is sampled, rather than followed live.

// File: rtl/cmsplit_pkg.sv
package cmsplit_pkg;

  typedef enum logic [1:0] {
    CMD_LINE_CINV   = 2'd0,
    CMD_RANGE_CLEAN = 2'd1,
    CMD_RANGE_INV   = 2'd2
  } cmdKind_e;

  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2
  } maintOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     advance;
    logic     selTail;
    cmdKind_e kind;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic planHead;
    logic planTail;
    logic planChunks;
    logic planClean;
    logic tailPend;
    logic chunksPend;
    logic moreAfter;
    logic doClean;
    logic doInv;
  } dpStat_t;

endpackage

// File: rtl/cmsplit_datapath.sv
module cmsplit_datapath
  import cmsplit_pkg::*;
#(
  parameter int AW              = 32,
  parameter int LINE_BYTES      = 32,
  parameter int MAX_CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES      = 4096
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] reqStart,
  input  logic [AW-1:0] reqEnd,
  input  logic [1:0]    reqOp,
  input  logic          wtOverride,
  input  dpCtrl_t       ctrl,
  output dpStat_t       stat,
  output logic [AW-1:0] cmdAddr,
  output logic [AW-1:0] cmdLast
);

  localparam logic [AW-1:0] LINE_MASK = AW'(LINE_BYTES - 1);
  localparam logic [AW-1:0] LINE_SIZE = AW'(LINE_BYTES);
  localparam logic [AW-1:0] CHUNK_MAX = AW'(MAX_CHUNK_BYTES);
  localparam logic [AW-1:0] PAGE_MASK = AW'(PAGE_BYTES - 1);

  // ---------------- request planning (combinational on request) ----------
  logic [AW-1:0] startLine, startUp, endLine, endUp;
  logic          startOff, endOff, isInv, isClean;
  logic [AW-1:0] cur0, end0;
  logic          headNeed, tailNeed, planClean, planInv;

  always_comb begin
    startLine = reqStart & ~LINE_MASK;
    endLine   = reqEnd & ~LINE_MASK;
    startOff  = |(reqStart & LINE_MASK);
    endOff    = |(reqEnd & LINE_MASK);
    startUp   = startOff ? startLine + LINE_SIZE : reqStart;
    endUp     = endOff ? endLine + LINE_SIZE : reqEnd;
    isInv     = (reqOp == OP_INV);
    isClean   = (reqOp == OP_CLEAN);
    planClean = !isInv && !wtOverride;
    planInv   = !isClean;
    if (isInv) begin
      headNeed = startOff;
      tailNeed = (startUp < reqEnd) && endOff;
      cur0     = startUp;
      end0     = tailNeed ? endLine : reqEnd;
    end else begin
      headNeed = 1'b0;
      tailNeed = 1'b0;
      cur0     = startLine;
      end0     = endUp;
    end
  end

  // ---------------- request state ----------------
  logic [AW-1:0] curReg, endReg, headReg, tailReg;
  logic          tailReg_q, cleanReg, invReg;
  logic [AW-1:0] chunkEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curReg    <= '0;
      endReg    <= '0;
      headReg   <= '0;
      tailReg   <= '0;
      tailReg_q <= 1'b0;
      cleanReg  <= 1'b0;
      invReg    <= 1'b0;
    end else if (ctrl.load) begin
      curReg    <= cur0;
      endReg    <= end0;
      headReg   <= startLine;
      tailReg   <= endLine;
      tailReg_q <= tailNeed;
      cleanReg  <= planClean;
      invReg    <= planInv;
    end else if (ctrl.advance) begin
      curReg <= chunkEnd;
    end
  end

  // ---------------- chunk boundary ----------------
  logic [AW-1:0] capEnd, pageEnd;
  always_comb begin
    capEnd   = curReg + CHUNK_MAX;
    pageEnd  = (curReg | PAGE_MASK) + AW'(1);
    chunkEnd = endReg;
    if (capEnd < chunkEnd)  chunkEnd = capEnd;
    if (pageEnd < chunkEnd) chunkEnd = pageEnd;
  end

  // ---------------- status and command payload ----------------
  always_comb begin
    stat.planHead   = headNeed;
    stat.planTail   = tailNeed;
    stat.planChunks = (cur0 < end0) && (planClean || planInv);
    stat.planClean  = planClean;
    stat.tailPend   = tailReg_q;
    stat.chunksPend = (curReg < endReg) && (cleanReg || invReg);
    stat.moreAfter  = chunkEnd < endReg;
    stat.doClean    = cleanReg;
    stat.doInv      = invReg;
  end

  always_comb begin
    if (ctrl.kind == CMD_LINE_CINV) begin
      cmdAddr = ctrl.selTail ? tailReg : headReg;
      cmdLast = cmdAddr;
    end else begin
      cmdAddr = curReg;
      cmdLast = chunkEnd - LINE_SIZE;
    end
  end

endmodule

// File: rtl/cmsplit_ctrl.sv
module cmsplit_ctrl
  import cmsplit_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    cmdReady,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    reqReady,
  output logic    cmdValid,
  output logic    done,
  output logic    barrier
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_HEAD, ST_TAIL, ST_RCLEAN, ST_RINV, ST_DONE, ST_BAR
  } state_e;

  state_e state, stateNext;
  logic   accept, hs;

  function automatic state_e chunkState(input logic withClean);
    return withClean ? ST_RCLEAN : ST_RINV;
  endfunction

  assign accept = reqValid && (state == ST_IDLE);
  assign hs     = cmdValid && cmdReady;

  always_comb begin
    stateNext    = state;
    ctrl.load    = accept;
    ctrl.advance = 1'b0;
    ctrl.selTail = (state == ST_TAIL);
    ctrl.kind    = CMD_LINE_CINV;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (stat.planHead)        stateNext = ST_HEAD;
        else if (stat.planTail)   stateNext = ST_TAIL;
        else if (stat.planChunks) stateNext = chunkState(stat.planClean);
        else                      stateNext = ST_DONE;
      end
      ST_HEAD: if (hs) begin
        if (stat.tailPend)        stateNext = ST_TAIL;
        else if (stat.chunksPend) stateNext = chunkState(stat.doClean);
        else                      stateNext = ST_DONE;
      end
      ST_TAIL: if (hs) begin
        if (stat.chunksPend) stateNext = chunkState(stat.doClean);
        else                 stateNext = ST_DONE;
      end
      ST_RCLEAN: begin
        ctrl.kind = CMD_RANGE_CLEAN;
        if (hs) begin
          if (stat.doInv) begin
            stateNext = ST_RINV;
          end else begin
            ctrl.advance = 1'b1;
            stateNext    = stat.moreAfter ? ST_RCLEAN : ST_DONE;
          end
        end
      end
      ST_RINV: begin
        ctrl.kind = CMD_RANGE_INV;
        if (hs) begin
          ctrl.advance = 1'b1;
          stateNext    = stat.moreAfter ? chunkState(stat.doClean) : ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_BAR;
      ST_BAR:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign cmdValid = (state == ST_HEAD) || (state == ST_TAIL) ||
                    (state == ST_RCLEAN) || (state == ST_RINV);
  assign done     = (state == ST_DONE);
  assign barrier  = (state == ST_BAR);

endmodule

// File: rtl/cache_range_splitter.sv
module cache_range_splitter
  import cmsplit_pkg::*;
#(
  parameter int AW              = 32,
  parameter int LINE_BYTES      = 32,
  parameter int MAX_CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES      = 4096
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [AW-1:0] reqStart,
  input  logic [AW-1:0] reqEnd,
  input  logic [1:0]    reqOp,
  input  logic          wtOverride,
  output logic          cmdValid,
  input  logic          cmdReady,
  output logic [1:0]    cmdKind,
  output logic [AW-1:0] cmdAddr,
  output logic [AW-1:0] cmdLast,
  output logic          done,
  output logic          barrier
);

  dpCtrl_t ctrl;
  dpStat_t stat;

  cmsplit_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cmdReady (cmdReady),
    .stat     (stat),
    .ctrl     (ctrl),
    .reqReady (reqReady),
    .cmdValid (cmdValid),
    .done     (done),
    .barrier  (barrier)
  );

  cmsplit_datapath #(
    .AW              (AW),
    .LINE_BYTES      (LINE_BYTES),
    .MAX_CHUNK_BYTES (MAX_CHUNK_BYTES),
    .PAGE_BYTES      (PAGE_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqStart   (reqStart),
    .reqEnd     (reqEnd),
    .reqOp      (reqOp),
    .wtOverride (wtOverride),
    .ctrl       (ctrl),
    .stat       (stat),
    .cmdAddr    (cmdAddr),
    .cmdLast    (cmdLast)
  );

  assign cmdKind = ctrl.kind;

endmodule

// File: rtl/cache_range_splitter_chk.sv
module cache_range_splitter_chk #(
  parameter int AW              = 32,
  parameter int LINE_BYTES      = 32,
  parameter int MAX_CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES      = 4096
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqReady,
  input logic          cmdValid,
  input logic          cmdReady,
  input logic [1:0]    cmdKind,
  input logic [AW-1:0] cmdAddr,
  input logic [AW-1:0] cmdLast,
  input logic          done,
  input logic          barrier
);

  localparam int PW = $clog2(PAGE_BYTES);
  localparam logic [AW-1:0] LMASK = AW'(LINE_BYTES - 1);

  // R10: payload held while stalled
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdKind) &&
                               $stable(cmdAddr) && $stable(cmdLast));

  // R3: chunk length and page containment
  a_r3_chunk_bounds: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdKind != 2'd0) |->
      ((cmdLast - cmdAddr) < AW'(MAX_CHUNK_BYTES)) &&
      (cmdLast[AW-1:PW] == cmdAddr[AW-1:PW]));

  // R2: line commands cover one line, all addresses aligned
  a_r2_line_form: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ((cmdAddr & LMASK) == '0) && ((cmdLast & LMASK) == '0) &&
                 ((cmdKind != 2'd0) || (cmdLast == cmdAddr)));

  // R11: done then barrier then ready
  a_r11_done_barrier: assert property (@(posedge clk) disable iff (!rstN)
    done |=> barrier && !done);

  a_r11_barrier_ready: assert property (@(posedge clk) disable iff (!rstN)
    barrier |=> reqReady && !barrier);

  // R1: idle excludes every other activity
  a_r1_idle_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !cmdValid && !done && !barrier);

endmodule

bind cache_range_splitter cache_range_splitter_chk #(
  .AW              (AW),
  .LINE_BYTES      (LINE_BYTES),
  .MAX_CHUNK_BYTES (MAX_CHUNK_BYTES),
  .PAGE_BYTES      (PAGE_BYTES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdKind  (cmdKind),
  .cmdAddr  (cmdAddr),
  .cmdLast  (cmdLast),
  .done     (done),
  .barrier  (barrier)
);

// File: tb/tb_cache_range_splitter.sv
module tb_cache_range_splitter;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqStart = '0;
  logic [AW-1:0] reqEnd = '0;
  logic [1:0]    reqOp = '0;
  logic          wtOverride = 1'b0;
  logic          cmdValid;
  logic          cmdReady = 1'b0;
  logic [1:0]    cmdKind;
  logic [AW-1:0] cmdAddr, cmdLast;
  logic          done, barrier;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  cache_range_splitter dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqStart(reqStart), .reqEnd(reqEnd), .reqOp(reqOp),
    .wtOverride(wtOverride), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdAddr(cmdAddr), .cmdLast(cmdLast),
    .done(done), .barrier(barrier)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        wt;
    logic [1:0]  pat;
    logic [31:0] s;
    logic [31:0] e;
    logic [7:0]  n;
  } vec_t;

  // op, wt, ready pattern, start, end, expected command count
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 2'd0, 32'h1000, 32'h1400, 8'd1},  // R7 inv aligned
    '{2'd0, 1'b0, 2'd1, 32'h1005, 32'h1033, 8'd2},  // R5 head+tail
    '{2'd0, 1'b0, 2'd0, 32'h1005, 32'h1010, 8'd1},  // R5 inside head line
    '{2'd1, 1'b0, 2'd2, 32'h0F10, 32'h1508, 8'd3},  // R3 page + cap
    '{2'd2, 1'b0, 2'd1, 32'h0F10, 32'h1508, 8'd6},  // R7 flush pairs
    '{2'd2, 1'b1, 2'd0, 32'h0F10, 32'h1508, 8'd3},  // R8 flush override
    '{2'd1, 1'b1, 2'd0, 32'h2000, 32'h2400, 8'd0},  // R8 clean override
    '{2'd0, 1'b0, 2'd0, 32'h3000, 32'h3000, 8'd0},  // R12 empty
    '{2'd0, 1'b0, 2'd2, 32'h2FF0, 32'h3850, 8'd5},  // R4 head tail chunks
    '{2'd1, 1'b0, 2'd0, 32'h4000, 32'h4001, 8'd1},  // R6 rounding
    '{2'd0, 1'b0, 2'd1, 32'h5000, 32'h5008, 8'd1},  // R5 aligned start
    '{2'd3, 1'b0, 2'd0, 32'h6000, 32'h7000, 8'd8}   // R6 op 3 as flush
  };

  function automatic string vecTag(input int i);
    case (i)
      0: return "R7"; 1: return "R5"; 2: return "R5"; 3: return "R3";
      4: return "R7"; 5: return "R8"; 6: return "R8"; 7: return "R12";
      8: return "R4"; 9: return "R6"; 10: return "R5"; default: return "R6";
    endcase
  endfunction

  logic [1:0]  expKind [64];
  logic [31:0] expAddr [64];
  logic [31:0] expLast [64];
  int          expN;

  function automatic void push(input logic [1:0] k, input logic [31:0] a,
                               input logic [31:0] l);
    if (expN < 64) begin
      expKind[expN] = k; expAddr[expN] = a; expLast[expN] = l;
    end
    expN++;
  endfunction

  // reference: expected command list from the requirements (R4..R9)
  function automatic void buildExp(input logic [1:0] op, input logic wt,
                                   input logic [31:0] s, input logic [31:0] e);
    logic [31:0] a, lim, pg, sEnd;
    bit doClean, doInv;
    expN = 0;
    a = s; sEnd = e;
    if (op == 2'd0) begin
      if (s % 32 != 0) begin
        push(2'd0, s - s % 32, s - s % 32);
        a = s - s % 32 + 32;
      end
      if (a < e && e % 32 != 0) begin
        push(2'd0, e - e % 32, e - e % 32);
        sEnd = e - e % 32;
      end
    end else begin
      a = s - s % 32;
      sEnd = (e % 32 != 0) ? e - e % 32 + 32 : e;
    end
    doClean = (op != 2'd0) && !wt;
    doInv   = (op != 2'd1);
    if (!doClean && !doInv) return;
    while (a < sEnd) begin
      lim = sEnd;
      if (a + 1024 < lim) lim = a + 1024;
      pg = (a / 4096 + 1) * 4096;
      if (pg < lim) lim = pg;
      if (doClean) push(2'd1, a, lim - 32);
      if (doInv)   push(2'd2, a, lim - 32);
      a = lim;
    end
  endfunction

  function automatic void check(input bit ok, input string tag,
                                input string what, input logic [31:0] act,
                                input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endfunction

  function automatic bit readyPat(input logic [1:0] p, input int c);
    case (p)
      2'd0: return 1'b1;
      2'd1: return (c % 2) == 1;
      default: return (c % 4) == 0;
    endcase
  endfunction

  task automatic runReq(input logic [1:0] op, input logic wt,
                        input logic [31:0] s, input logic [31:0] e,
                        input logic [1:0] pat, input logic wtAfter,
                        input bit poke, input int expCount, input string tag);
    int idx, cyc, lastHs, doneCyc;
    bit gotDone, prevStall;
    logic [1:0] pk;
    logic [31:0] pa, pl;
    buildExp(op, wt, s, e);
    check(expN == expCount, tag, "model count", expN, expCount);
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready before request", reqReady, 1);
    reqValid = 1'b1; reqOp = op; reqStart = s; reqEnd = e; wtOverride = wt;
    @(posedge clk);
    #1;
    reqValid = 1'b0; reqStart = '0; reqEnd = '0; reqOp = 2'd1;
    wtOverride = wtAfter;
    idx = 0; cyc = 0; lastHs = 0; gotDone = 0; doneCyc = 0; prevStall = 0;
    pk = '0; pa = '0; pl = '0;
    while (!gotDone && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc >= 1) begin
        reqValid = 1'b1; reqOp = 2'd1; reqStart = 32'h9000; reqEnd = 32'h9400;
        check(reqReady == 1'b0, "R1", "ready while busy", reqReady, 0);
      end
      if (prevStall) begin
        check(cmdValid && cmdKind == pk && cmdAddr == pa && cmdLast == pl,
              "R10", "payload held", cmdAddr, pa);
      end
      cmdReady = readyPat(pat, cyc);
      prevStall = cmdValid && !cmdReady;
      pk = cmdKind; pa = cmdAddr; pl = cmdLast;
      if (done) begin
        gotDone = 1; doneCyc = cyc;
        reqValid = 1'b0;
        check(cmdValid == 1'b0, "R11", "no command with done", cmdValid, 0);
      end else if (cmdValid && cmdReady) begin
        if (idx < expN && idx < 64) begin
          // order and content per R2 and R9
          check(cmdKind == expKind[idx], tag, "R2 kind", cmdKind, expKind[idx]);
          check(cmdAddr == expAddr[idx], tag, "R9 addr", cmdAddr, expAddr[idx]);
          check(cmdLast == expLast[idx], tag, "R2 last", cmdLast, expLast[idx]);
        end else begin
          check(1'b0, tag, "unexpected command", cmdAddr, 0);
        end
        idx++;
        lastHs = cyc;
      end
    end
    cmdReady = 1'b0;
    check(gotDone, "R11", "done seen", gotDone, 1);
    check(idx == expCount, tag, "command count", idx, expCount);
    if (expCount == 0)
      check(doneCyc == 1, "R12", "empty done cycle", doneCyc, 1);
    else
      check(doneCyc == lastHs + 1, "R11", "done after last", doneCyc, lastHs + 1);
    @(negedge clk);
    check(barrier == 1'b1 && done == 1'b0, "R11", "barrier pulse", barrier, 1);
    @(negedge clk);
    check(barrier == 1'b0 && reqReady == 1'b1, "R11", "ready after barrier",
          reqReady, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // reset state R1
    check(reqReady == 1'b1, "R1", "reset ready", reqReady, 1);
    check(cmdValid == 1'b0, "R1", "reset cmdValid", cmdValid, 0);
    check(done == 1'b0 && barrier == 1'b0, "R11", "reset pulses", done, 0);

    for (int i = 0; i < NV; i++) begin
      runReq(VEC[i].op, VEC[i].wt, VEC[i].s, VEC[i].e, VEC[i].pat,
             VEC[i].wt, 1'b0, int'(VEC[i].n), vecTag(i));
    end

    // R1: override sampled at accept, busy requests ignored (R8 flush)
    runReq(2'd2, 1'b1, 32'h8000, 32'h8400, 2'd1, 1'b0, 1'b1, 1, "R1");
    // R8: override raised after accept does not suppress cleaning
    runReq(2'd1, 1'b0, 32'h8000, 32'h8040, 2'd0, 1'b1, 1'b0, 1, "R8");
    // R3: chunk at page end, start at last line of a page
    runReq(2'd0, 1'b0, 32'h1FE0, 32'h2020, 2'd2, 1'b0, 1'b0, 2, "R3");

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule